// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer with Shared Setups

This block drives an external conversion engine from a table of channel entries. Each entry carries an enable bit, a positive and a negative input selector, and a pointer into a small shared pool of setup records. A setup record holds a gain code, a filter type, an output data rate, an input buffer enable and a reference selector. Any number of channels can point at the same setup.

The sequencer walks the enabled entries in ascending index order and wraps around. For each entry it issues a one-cycle start strobe. Together with the strobe it presents the selectors and the resolved setup fields. It then waits for a done pulse and returns the engine's result tagged with the channel index. Input selector codes are passed through untouched. An entry that names an internal check source, such as a supply or a reference monitor, is therefore scheduled exactly like an ordinary analog pair.

Software programs the tables through a flat write port and a combinational read port. The fields presented to the engine are a snapshot taken at the start strobe, so table writes never disturb a conversion that is already running.

Top module: `conv_seq`

## Requirements
- R1: Address bit 4 = 0 selects channel entry addr[3:0]; address bit 4 = 1 selects setup addr[2:0]. Channel word: enable bit 0, positive select bits 5:1, negative select bits 10:6, setup pointer bits 13:11. Setup word: gain code bits 2:0, filter type bits 5:3, data rate bits 16:6, buffer enable bit 17, reference select bits 19:18. A write happens on a clock edge with reg_we_i high. Reads are combinational and return 0 in all unused bits.
- R2: After reset, all entries and setups read as zero, and neither conv_start_o nor res_valid_o is asserted.
- R3: While no entry is enabled and no conversion is outstanding, no start strobe is issued.
- R4: Channels are converted in ascending index order and wrap from the highest enabled index to the lowest. The first scan after reset begins at index 0.
- R5: Disabled entries cost no slot. When any entry is enabled, the next start strobe comes in the cycle right after res_valid_o.
- R6: conv_start_o is a single-cycle pulse. With it, conv_ch_o, the selectors and the fields of the setup the entry points at appear on the outputs. They hold until the next strobe.
- R7: A gain code g means gain 2^g. When g is nonzero, conv_buf_o is 1. When g is 0, conv_buf_o follows the setup's buffer enable bit.
- R8: All 32 selector codes, including diagnostic codes 16 to 31, are sequenced and presented unchanged.
- R9: A conv_done_i pulse that arrives while no conversion is outstanding produces no result.
- R10: In the cycle after a conv_done_i is accepted, res_valid_o is high for exactly one cycle. In that cycle res_data_o equals the engine's data and res_tag_o equals the channel index.
- R11: A channel or setup write made during a conversion leaves that conversion's outputs unchanged and applies from the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| conv_start_o | output | 1 | Start strobe to the conversion engine |
| conv_ch_o | output | 4 | Channel index of the current conversion |
| conv_pos_o | output | 5 | Positive input selector |
| conv_neg_o | output | 5 | Negative input selector |
| conv_gain_o | output | 3 | Gain code (gain = 2^code) |
| conv_filt_o | output | 3 | Filter type |
| conv_odr_o | output | 11 | Output data rate code |
| conv_buf_o | output | 1 | Effective input buffer enable |
| conv_ref_o | output | 2 | Reference selector |
| conv_done_i | input | 1 | Conversion done pulse from the engine |
| conv_data_i | input | 24 | Conversion result from the engine |
| res_valid_o | output | 1 | Result valid pulse |
| res_data_o | output | 24 | Result data |
| res_tag_o | output | 4 | Channel tag of the result |

## Verification
A start strobe appears one cycle after the edge at which the idle sequencer sees an enabled entry. A result appears one cycle after the edge that samples done. The next start follows one cycle after that result, and reads are valid in the same cycle as the address. The bench drives inputs on falling edges and waits for each strobe with a bounded loop. It then compares every presented field against its own mirror of the tables. It holds done back two cycles, checks the result in the exact cycle after done is sampled, and checks the following strobe in the cycle after that. It sweeps several enable patterns, with wrap, a single entry and the full set, and edits setups in the middle of a conversion to show that the change lands only on the next strobe.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int REG_W  = 32;
  localparam int SEL_W  = 5;
  localparam int N_SU   = 8;
  localparam int SU_W   = $clog2(N_SU);
  localparam int GAIN_W = 3;
  localparam int FILT_W = 3;
  localparam int ODR_W  = 11;
  localparam int REF_W  = 2;

  typedef struct packed {
    logic [SU_W-1:0]  su;
    logic [SEL_W-1:0] neg;
    logic [SEL_W-1:0] pos;
    logic             en;
  } ch_entry_t;

  typedef struct packed {
    logic [REF_W-1:0]  refsel;
    logic              buf_en;
    logic [ODR_W-1:0]  odr;
    logic [FILT_W-1:0] filt;
    logic [GAIN_W-1:0] gain;
  } setup_t;

  localparam int CH_BITS = $bits(ch_entry_t);
  localparam int SU_BITS = $bits(setup_t);

  function automatic ch_entry_t ch_unpack(logic [REG_W-1:0] w);
    return ch_entry_t'(w[CH_BITS-1:0]);
  endfunction

  function automatic logic [REG_W-1:0] ch_pack(ch_entry_t e);
    return {{(REG_W-CH_BITS){1'b0}}, e};
  endfunction

  function automatic setup_t su_unpack(logic [REG_W-1:0] w);
    return setup_t'(w[SU_BITS-1:0]);
  endfunction

  function automatic logic [REG_W-1:0] su_pack(setup_t s);
    return {{(REG_W-SU_BITS){1'b0}}, s};
  endfunction
endpackage

// File: rtl/conv_seq_regs.sv
module conv_seq_regs
  import conv_seq_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int CH_W   = $clog2(N_CH),
  parameter int ADDR_W = CH_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [REG_W-1:0]        rdata_o,
  output ch_entry_t [N_CH-1:0]    ch_tab_o,
  output setup_t [N_SU-1:0]       su_tab_o
);
  logic sel_su;
  assign sel_su = addr_i[ADDR_W-1];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    ch_entry_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && !sel_su && addr_i[CH_W-1:0] == CH_W'(g)) q <= ch_unpack(wdata_i);
    end
    assign ch_tab_o[g] = q;
  end

  for (genvar g = 0; g < N_SU; g++) begin : g_su
    setup_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && sel_su && addr_i[SU_W-1:0] == SU_W'(g)) q <= su_unpack(wdata_i);
    end
    assign su_tab_o[g] = q;
  end

  always_comb begin
    if (sel_su) rdata_o = su_pack(su_tab_o[addr_i[SU_W-1:0]]);
    else        rdata_o = ch_pack(ch_tab_o[addr_i[CH_W-1:0]]);
  end
endmodule

// File: rtl/conv_seq_pick.sv
module conv_seq_pick #(
  parameter int N_CH = 16,
  parameter int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] en_i,
  input  logic [CH_W-1:0] cursor_i,
  output logic            found_o,
  output logic [CH_W-1:0] idx_o
);
  logic [2*N_CH-1:0] dbl;
  logic [N_CH-1:0]   win;
  logic [CH_W-1:0]   off;
  logic [CH_W:0]     sum;

  // rotate so the cursor sits at bit 0, then take the lowest set bit
  assign dbl = {en_i, en_i} >> cursor_i;
  assign win = dbl[N_CH-1:0];

  always_comb begin
    off = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (win[i]) off = CH_W'(i);
    end
  end

  assign sum     = {1'b0, cursor_i} + {1'b0, off};
  assign found_o = |en_i;
  assign idx_o   = (sum >= (CH_W+1)'(N_CH)) ? CH_W'(sum - (CH_W+1)'(N_CH)) : sum[CH_W-1:0];
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_seq_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int CH_W   = $clog2(N_CH),
  parameter int DATA_W = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  ch_entry_t [N_CH-1:0] ch_tab_i,
  input  setup_t [N_SU-1:0]    su_tab_i,
  input  logic                 pick_found_i,
  input  logic [CH_W-1:0]      pick_idx_i,
  output logic [CH_W-1:0]      cursor_o,
  output logic                 busy_o,
  output logic                 start_o,
  output logic [CH_W-1:0]      ch_o,
  output logic [SEL_W-1:0]     pos_o,
  output logic [SEL_W-1:0]     neg_o,
  output logic [GAIN_W-1:0]    gain_o,
  output logic [FILT_W-1:0]    filt_o,
  output logic [ODR_W-1:0]     odr_o,
  output logic                 buf_o,
  output logic [REF_W-1:0]     ref_o,
  input  logic                 done_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic                 res_valid_o,
  output logic [DATA_W-1:0]    res_data_o,
  output logic [CH_W-1:0]      res_tag_o
);
  typedef enum logic {S_IDLE, S_BUSY} state_e;
  state_e    state_q;
  ch_entry_t sel_ch;
  setup_t    sel_su;
  logic [CH_W-1:0] next_cursor;

  assign sel_ch = ch_tab_i[pick_idx_i];
  assign sel_su = su_tab_i[sel_ch.su];
  assign next_cursor = (ch_o == CH_W'(N_CH - 1)) ? '0 : ch_o + CH_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cursor_o    <= '0;
      start_o     <= 1'b0;
      ch_o        <= '0;
      pos_o       <= '0;
      neg_o       <= '0;
      gain_o      <= '0;
      filt_o      <= '0;
      odr_o       <= '0;
      buf_o       <= 1'b0;
      ref_o       <= '0;
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
    end else begin
      start_o     <= 1'b0;
      res_valid_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (pick_found_i) begin
            // snapshot: later table writes wait for the next strobe
            start_o <= 1'b1;
            ch_o    <= pick_idx_i;
            pos_o   <= sel_ch.pos;
            neg_o   <= sel_ch.neg;
            gain_o  <= sel_su.gain;
            filt_o  <= sel_su.filt;
            odr_o   <= sel_su.odr;
            buf_o   <= (sel_su.gain != '0) | sel_su.buf_en;
            ref_o   <= sel_su.refsel;
            state_q <= S_BUSY;
          end
        end
        S_BUSY: begin
          if (done_i) begin
            res_valid_o <= 1'b1;
            res_data_o  <= data_i;
            cursor_o    <= next_cursor;
            state_q     <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q == S_BUSY);
  assign res_tag_o = ch_o;
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int  N_CH   = 16,
  parameter int  DATA_W = 24,
  localparam int CH_W   = $clog2(N_CH),
  localparam int ADDR_W = CH_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               conv_start_o,
  output logic [CH_W-1:0]    conv_ch_o,
  output logic [SEL_W-1:0]   conv_pos_o,
  output logic [SEL_W-1:0]   conv_neg_o,
  output logic [GAIN_W-1:0]  conv_gain_o,
  output logic [FILT_W-1:0]  conv_filt_o,
  output logic [ODR_W-1:0]   conv_odr_o,
  output logic               conv_buf_o,
  output logic [REF_W-1:0]   conv_ref_o,
  input  logic               conv_done_i,
  input  logic [DATA_W-1:0]  conv_data_i,
  output logic               res_valid_o,
  output logic [DATA_W-1:0]  res_data_o,
  output logic [CH_W-1:0]    res_tag_o
);
  ch_entry_t [N_CH-1:0] ch_tab;
  setup_t [N_SU-1:0]    su_tab;
  logic [N_CH-1:0]      ch_en;
  logic [CH_W-1:0]      cursor;
  logic [CH_W-1:0]      pick_idx;
  logic                 pick_found;
  logic                 seq_busy;

  for (genvar g = 0; g < N_CH; g++) begin : g_en
    assign ch_en[g] = ch_tab[g].en;
  end

  conv_seq_regs #(.N_CH(N_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .ch_tab_o (ch_tab),
    .su_tab_o (su_tab)
  );

  conv_seq_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick (
    .en_i     (ch_en),
    .cursor_i (cursor),
    .found_o  (pick_found),
    .idx_o    (pick_idx)
  );

  conv_seq_fsm #(.N_CH(N_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ch_tab_i     (ch_tab),
    .su_tab_i     (su_tab),
    .pick_found_i (pick_found),
    .pick_idx_i   (pick_idx),
    .cursor_o     (cursor),
    .busy_o       (seq_busy),
    .start_o      (conv_start_o),
    .ch_o         (conv_ch_o),
    .pos_o        (conv_pos_o),
    .neg_o        (conv_neg_o),
    .gain_o       (conv_gain_o),
    .filt_o       (conv_filt_o),
    .odr_o        (conv_odr_o),
    .buf_o        (conv_buf_o),
    .ref_o        (conv_ref_o),
    .done_i       (conv_done_i),
    .data_i       (conv_data_i),
    .res_valid_o  (res_valid_o),
    .res_data_o   (res_data_o),
    .res_tag_o    (res_tag_o)
  );
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int N_CH = 16,
  parameter int CH_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            done_i,
  input logic            busy_i,
  input logic [N_CH-1:0] ch_en_i,
  input logic [CH_W-1:0] conv_ch_i,
  input logic [4:0]      pos_i,
  input logic [4:0]      neg_i,
  input logic [2:0]      gain_i,
  input logic [2:0]      filt_i,
  input logic [10:0]     odr_i,
  input logic            buf_i,
  input logic [1:0]      ref_i,
  input logic            res_valid_i,
  input logic [CH_W-1:0] res_tag_i
);
  p_start_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !start_i);

  p_hold_fields_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |-> ($stable(conv_ch_i) && $stable(pos_i) && $stable(neg_i) && $stable(gain_i)
                  && $stable(filt_i) && $stable(odr_i) && $stable(buf_i) && $stable(ref_i)));

  p_buf_forced_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && gain_i != 3'd0) |-> buf_i);

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && ch_en_i == '0) |=> !start_i);

  p_stray_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && done_i) |=> !res_valid_i);

  p_res_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> !res_valid_i);

  p_tag_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |-> (res_tag_i == conv_ch_i));

  p_start_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> busy_i);
endmodule

bind conv_seq conv_seq_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (conv_start_o),
  .done_i      (conv_done_i),
  .busy_i      (seq_busy),
  .ch_en_i     (ch_en),
  .conv_ch_i   (conv_ch_o),
  .pos_i       (conv_pos_o),
  .neg_i       (conv_neg_o),
  .gain_i      (conv_gain_o),
  .filt_i      (conv_filt_o),
  .odr_i       (conv_odr_o),
  .buf_i       (conv_buf_o),
  .ref_i       (conv_ref_o),
  .res_valid_i (res_valid_o),
  .res_tag_i   (res_tag_o)
);

// File: tb/conv_seq_tb.sv
module conv_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        conv_start_o;
  logic [3:0]  conv_ch_o;
  logic [4:0]  conv_pos_o, conv_neg_o;
  logic [2:0]  conv_gain_o, conv_filt_o;
  logic [10:0] conv_odr_o;
  logic        conv_buf_o;
  logic [1:0]  conv_ref_o;
  logic        conv_done_i = 1'b0;
  logic [23:0] conv_data_i = '0;
  logic        res_valid_o;
  logic [23:0] res_data_o;
  logic [3:0]  res_tag_o;

  always #5 clk_i = ~clk_i;

  conv_seq dut_i (.*);

  int n_chk = 0, n_bad = 0, cur = 0, seqno = 0;
  logic [15:0] m_en = '0;
  logic [4:0]  m_pos [16];
  logic [4:0]  m_neg [16];
  logic [2:0]  m_su  [16];
  logic [2:0]  m_gain[8];
  logic [2:0]  m_filt[8];
  logic [10:0] m_odr [8];
  logic        m_buf [8];
  logic [1:0]  m_ref [8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic wr_ch(input int c);
    reg_write({1'b0, 4'(c)}, {18'd0, m_su[c], m_neg[c], m_pos[c], m_en[c]});
  endtask

  task automatic wr_su(input int s);
    reg_write({2'b10, 3'(s)}, {12'd0, m_ref[s], m_buf[s], m_odr[s], m_filt[s], m_gain[s]});
  endtask

  function automatic int pick_next(input int from);
    for (int i = 0; i < 16; i++) if (m_en[(from + i) % 16]) return (from + i) % 16;
    return -1;
  endfunction

  // waits for the strobe and compares every presented field with the mirror
  task automatic conv_begin(output int ch);
    int t = 0;
    int s;
    while (!conv_start_o && t < 50) begin @(negedge clk_i); t++; end
    chk(conv_start_o, "R6 start seen", 32'(conv_start_o), 1);
    ch = pick_next(cur);
    s = m_su[ch];
    chk(conv_ch_o == 4'(ch), "R4 order", 32'(conv_ch_o), 32'(ch));
    chk(conv_pos_o == m_pos[ch] && conv_neg_o == m_neg[ch], "R8 selectors",
        {conv_pos_o, conv_neg_o}, {m_pos[ch], m_neg[ch]});
    chk(conv_gain_o == m_gain[s] && conv_filt_o == m_filt[s] && conv_odr_o == m_odr[s]
        && conv_ref_o == m_ref[s], "R6 setup fields",
        {conv_ref_o, conv_odr_o, conv_filt_o, conv_gain_o}, {m_ref[s], m_odr[s], m_filt[s], m_gain[s]});
    chk(conv_buf_o == ((m_gain[s] != 0) | m_buf[s]), "R7 buffer", 32'(conv_buf_o),
        32'((m_gain[s] != 0) | m_buf[s]));
    @(negedge clk_i);
    chk(!conv_start_o, "R6 single pulse", 32'(conv_start_o), 0);
  endtask

  task automatic conv_end(input int ch);
    logic [23:0] d;
    seqno++;
    d = 24'((seqno * 7919 + ch * 65537) & 24'hFFFFFF);
    @(negedge clk_i);
    conv_done_i = 1'b1; conv_data_i = d;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    chk(res_valid_o && res_data_o == d && res_tag_o == 4'(ch), "R10 result",
        {res_valid_o, res_tag_o, res_data_o}, {1'b1, 4'(ch), d});
    cur = (ch + 1) % 16;
    @(negedge clk_i);
    chk(!res_valid_o, "R10 single result", 32'(res_valid_o), 0);
    if (m_en != 0) chk(conv_start_o, "R5 next start", 32'(conv_start_o), 1);
    else           chk(!conv_start_o, "R3 stop", 32'(conv_start_o), 0);
  endtask

  initial begin
    logic [15:0] pats [6];
    int ch, s, starts;
    logic [2:0] g0; logic b0; logic [4:0] p0;
    pats[0] = 16'h0001; pats[1] = 16'h8001; pats[2] = 16'hA5A5;
    pats[3] = 16'h0F00; pats[4] = 16'hFFFF; pats[5] = 16'h4000;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!conv_start_o && !res_valid_o, "R2 outputs", {conv_start_o, res_valid_o}, 0);
    for (int a = 0; a < 32; a++) begin
      reg_addr_i = 5'(a); #1;
      chk(reg_rdata_o == 0, "R2 regs zero", reg_rdata_o, 0);
    end
    starts = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk_i); if (conv_start_o) starts++; end
    chk(starts == 0, "R3 idle after reset", 32'(starts), 0);

    for (int k = 0; k < 8; k++) begin
      m_gain[k] = 3'(k); m_filt[k] = 3'(7 - k); m_odr[k] = 11'(k * 211 + 5);
      m_buf[k] = k[1]; m_ref[k] = 2'(k); wr_su(k);
    end
    for (int c = 0; c < 16; c++) begin
      m_pos[c] = 5'(c); m_neg[c] = 5'(31 - c); m_su[c] = 3'((c * 3) % 8); wr_ch(c);
    end
    reg_addr_i = 5'd5; #1;
    chk(reg_rdata_o == {18'd0, m_su[5], m_neg[5], m_pos[5], 1'b0}, "R1 channel read",
        reg_rdata_o, {18'd0, m_su[5], m_neg[5], m_pos[5], 1'b0});
    reg_addr_i = 5'h13; #1;
    chk(reg_rdata_o == {12'd0, m_ref[3], m_buf[3], m_odr[3], m_filt[3], m_gain[3]}, "R1 setup read",
        reg_rdata_o, {12'd0, m_ref[3], m_buf[3], m_odr[3], m_filt[3], m_gain[3]});
    chk(!conv_start_o, "R3 idle while disabled", 32'(conv_start_o), 0);

    m_en[0] = 1'b1; wr_ch(0);
    for (int p = 0; p < 6; p++) begin
      conv_begin(ch);
      s = m_su[ch];
      g0 = conv_gain_o; b0 = conv_buf_o; p0 = conv_pos_o;
      m_gain[s] = m_gain[s] + 3'd1; m_buf[s] = ~m_buf[s]; wr_su(s);
      m_pos[ch] = m_pos[ch] ^ 5'h10; wr_ch(ch);
      @(negedge clk_i);
      chk(conv_gain_o == g0 && conv_buf_o == b0 && conv_pos_o == p0, "R11 held during conversion",
          {conv_gain_o, conv_buf_o, conv_pos_o}, {g0, b0, p0});
      for (int c = 0; c < 16; c++) begin m_en[c] = pats[p][c]; wr_ch(c); end
      conv_end(ch);
      for (int n = 0; n < $countones(pats[p]) + 2; n++) begin
        conv_begin(ch);
        conv_end(ch);
      end
    end

    conv_begin(ch);
    m_en = '0;
    for (int c = 0; c < 16; c++) wr_ch(c);
    conv_end(ch);
    starts = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk_i); if (conv_start_o) starts++; end
    chk(starts == 0, "R3 idle after disable", 32'(starts), 0);
    conv_done_i = 1'b1; conv_data_i = 24'h123456;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    chk(!res_valid_o, "R9 stray done", 32'(res_valid_o), 0);
    @(negedge clk_i);
    chk(!res_valid_o, "R9 stray done later", 32'(res_valid_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule